// File: doc/BRIEF.md
# Reloadable Watchdog Timer with Prescaler

The block is a watchdog that raises a reset request when software fails to service it in time. A prescaler feeds a 16-bit up-counter from the system clock divided by 2 or by 128. Each service loads the counter's upper byte from an 8-bit reload setting and clears its lower byte. When the counter rolls over from its all-ones value, the reset request pulses for a fixed number of system clocks. A sticky flag records that a watchdog reset took place.

Software writes settings and service commands through a small write-only port. A service needs two writes in a row: an arm write, then a confirm write as the very next access. Once the start input has started the watchdog, nothing but the block's own reset can stop it. Counting pauses while the clock-enable input is low, or while either the idle or the power-down input is high.

The time from a service to the reset request is 2^(1+6·sel) × (65536 − reload×256) system clocks. With reload 0xFF and sel 0 this is 512 clocks. The reload and divider settings may be written at any time. They take effect only when the counter is next loaded.

Top module: `wdog_top`

## Requirements
- R1: After `rst_ni` is released, `wdt_rst_o` and `wdt_status_o` are 0, the watchdog is stopped, and the settings are reload 0x00 and sel 0.
- R2: While the watchdog is stopped, no reset request is raised and service writes have no effect. A one-cycle pulse on `start_i` starts it and loads the counter as a service would. A pulse on `start_i` while it runs is ignored.
- R3: With divider select 0 the counter advances once every 2 active clocks, and with select 1 once every 128. The reset request rises exactly 2^(1+6·sel) × (65536 − reload×256) active clocks after the clock edge that loaded the counter: 512 for reload 0xFF with sel 0, and 32768 for reload 0xFF with sel 1.
- R4: A write to address 2 (arm) followed, as the next write, by a write to address 3 (confirm) is a service. On the confirm edge, the counter's upper byte takes the reload setting, its lower byte and the prescaler phase clear, and the timeout restarts in full.
- R5: Any write other than a confirm, made after an arm, cancels the arm. A confirm write without a pending arm is ignored. The data value of arm and confirm writes is ignored.
- R6: A write to address 0 sets the 8-bit reload value. A write to address 1 sets the divider select from data bit 0. New settings take effect only at the next counter load (service, start, or restart after overflow), never on the running count.
- R7: The counter and the prescaler hold their value in every cycle in which `idle_i` is 1, `pwrdn_i` is 1, or `clk_en_i` is 0. Each such cycle pushes the reset request back by one cycle.
- R8: On overflow, `wdt_rst_o` goes high in the next cycle and stays high for 16 cycles. In the same edge the counter reloads from the current settings and keeps running.
- R9: `wdt_status_o` goes to 1 on overflow and stays 1 until a write to address 1 with data bit 1 set clears it.
- R10: A service whose confirm edge is the same edge as an overflow wins. No reset request is raised, the status flag is not set, and a full timeout starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_en_i | input | 1 | Counting enable; 0 freezes prescaler and counter |
| idle_i | input | 1 | Idle mode indication; 1 freezes prescaler and counter |
| pwrdn_i | input | 1 | Power-down mode indication; 1 freezes prescaler and counter |
| start_i | input | 1 | Start pulse; starts the watchdog, which then cannot be stopped |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 reload, 1 mode, 2 arm, 3 confirm |
| wr_data_i | input | 8 | Write data |
| wdt_rst_o | output | 1 | Reset request pulse, 16 cycles |
| wdt_status_o | output | 1 | Sticky flag: a watchdog reset occurred |

## Verification
Service and overflow can fall on the same clock edge. The bench serves the counter and waits 510 cycles, so the arm lands on edge 511 and the confirm on edge 512, which is the edge where the counter would overflow. It then expects the reset output and the status flag to stay low, and the next reset to rise exactly 512 cycles after that confirm edge. A second coincidence is a start pulse or a settings write while the counter runs: the bench shows that each leaves the pending timeout unchanged.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned RLD_W  = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_RELOAD  = 2'd0;
  localparam logic [ADDR_W-1:0] A_MODE    = 2'd1;
  localparam logic [ADDR_W-1:0] A_ARM     = 2'd2;
  localparam logic [ADDR_W-1:0] A_CONFIRM = 2'd3;

  localparam int unsigned MODE_SEL_BIT = 0;
  localparam int unsigned MODE_CLR_BIT = 1;

  typedef struct packed {
    logic [RLD_W-1:0] reload;
    logic             sel;
  } wdog_cfg_t;
endpackage

// File: rtl/wdog_regif.sv
module wdog_regif
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [RLD_W-1:0]  wr_data_i,
  output wdog_cfg_t         cfg_o,
  output logic              svc_o,
  output logic              clr_o
);
  wdog_cfg_t cfg_q;
  logic      armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_RELOAD) cfg_q.reload <= wr_data_i;
      if (wr_addr_i == A_MODE)   cfg_q.sel    <= wr_data_i[MODE_SEL_BIT];
    end
  end

  // any access re-decides the arm; only an arm write leaves it set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (wr_en_i) armed_q <= (wr_addr_i == A_ARM);
  end

  assign cfg_o = cfg_q;
  assign svc_o = wr_en_i && (wr_addr_i == A_CONFIRM) && armed_q;
  assign clr_o = wr_en_i && (wr_addr_i == A_MODE) && wr_data_i[MODE_CLR_BIT];

  a_r5_arm_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_o |=> !armed_q);
  a_r5_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_CONFIRM && !armed_q) |-> !svc_o);
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned LO_LOG2 = 1,
  parameter int unsigned HI_LOG2 = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic restart_i,
  input  logic sel_i,
  output logic tick_o
);
  localparam int unsigned PW = HI_LOG2;
  localparam logic [PW-1:0] LIM_LO = PW'((1 << LO_LOG2) - 1);
  localparam logic [PW-1:0] LIM_HI = PW'((1 << HI_LOG2) - 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] lim;

  assign lim    = sel_i ? LIM_HI : LIM_LO;
  assign tick_o = adv_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else if (adv_i)     cnt_q <= cnt_q + 1'b1;
  end

  a_r3_phase_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim);
  a_r7_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !restart_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned RLD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [RLD_W-1:0] reload_i,
  input  logic             tick_i,
  output logic             ovf_o
);
  localparam int unsigned LOW_W = CNT_W - RLD_W;

  logic [CNT_W-1:0] cnt_q;

  assign ovf_o = run_i && tick_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= {reload_i, {LOW_W{1'b0}}};
    else if (run_i && tick_i)   cnt_q <= cnt_q + 1'b1;
  end

  a_r4_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == {$past(reload_i), {LOW_W{1'b0}}}));
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
  parameter int unsigned RST_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic clr_i,
  output logic rst_req_o,
  output logic status_o
);
  localparam int unsigned LW = $clog2(RST_LEN + 1);
  localparam logic [LW-1:0] LAST = LW'(RST_LEN - 1);

  logic          rst_q;
  logic [LW-1:0] cnt_q;
  logic          status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b0;
      cnt_q <= '0;
    end else if (ovf_i) begin
      rst_q <= 1'b1;
      cnt_q <= LAST;
    end else if (rst_q) begin
      if (cnt_q == '0) rst_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // set wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    status_q <= 1'b0;
    else if (ovf_i) status_q <= 1'b1;
    else if (clr_i) status_q <= 1'b0;
  end

  assign rst_req_o = rst_q;
  assign status_o  = status_q;

  a_r8_rise_from_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_q) |-> $past(ovf_i));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_q && cnt_q != '0) |=> rst_q);
  a_r9_status_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> status_q);
  a_r9_status_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q && !clr_i) |=> status_q);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned LO_LOG2 = 1,
  parameter int unsigned HI_LOG2 = 7,
  parameter int unsigned RST_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              idle_i,
  input  logic              pwrdn_i,
  input  logic              start_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [RLD_W-1:0]  wr_data_i,
  output logic              wdt_rst_o,
  output logic              wdt_status_o
);
  wdog_cfg_t cfg;
  logic      svc, clr, svc_run;
  logic      run_q, act_sel_q;
  logic      adv, tick, ovf_raw, ovf_eff, ld;

  wdog_regif u_regif (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .svc_o     (svc),
    .clr_o     (clr)
  );

  assign svc_run = svc && run_q;
  assign ovf_eff = ovf_raw && !svc_run;  // service wins a tie
  assign ld      = (start_i && !run_q) || svc_run || ovf_eff;
  assign adv     = run_q && clk_en_i && !idle_i && !pwrdn_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 1'b0;
    else if (start_i) run_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  act_sel_q <= 1'b0;
    else if (ld)  act_sel_q <= cfg.sel;
  end

  wdog_prescaler #(.LO_LOG2(LO_LOG2), .HI_LOG2(HI_LOG2)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .restart_i (ld),
    .sel_i     (act_sel_q),
    .tick_o    (tick)
  );

  wdog_counter #(.CNT_W(CNT_W), .RLD_W(RLD_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_q),
    .load_i   (ld),
    .reload_i (cfg.reload),
    .tick_i   (tick),
    .ovf_o    (ovf_raw)
  );

  wdog_rstgen #(.RST_LEN(RST_LEN)) u_rst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ovf_i     (ovf_eff),
    .clr_i     (clr),
    .rst_req_o (wdt_rst_o),
    .status_o  (wdt_status_o)
  );

  a_r2_stopped_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !ovf_raw);
  a_r2_run_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q);
  a_r7_frozen_no_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i || pwrdn_i || !clk_en_i) |-> !ovf_raw);
  a_r10_svc_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_run |=> !$rose(wdt_rst_o));
endmodule

// File: tb/wdog_top_test.sv
`timescale 1ns/1ps
module wdog_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b1, idle = 1'b0, pwrdn = 1'b0, start = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wdt_rst, wdt_status;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdog_top uut (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(clk_en), .idle_i(idle),
    .pwrdn_i(pwrdn), .start_i(start), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wdt_rst_o(wdt_rst), .wdt_status_o(wdt_status)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int exp_period(input logic [7:0] r, input bit s);
    return (1 << (1 + 6 * s)) * (65536 - int'(r) * 256);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic service();
    wr(2'd2, $urandom);
    wr(2'd3, $urandom);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  // reset must stay low for p-1 edges, rise at edge p, hold 16 cycles
  task automatic chk_timeout(input int p, input string tag);
    int early = -1, lows = 0;
    for (int i = 1; i < p; i++) begin
      @(posedge clk); @(negedge clk);
      if (wdt_rst && early < 0) early = i;
    end
    check(early < 0, {tag, " early reset"}, early, p);
    @(posedge clk); @(negedge clk);
    check(wdt_rst === 1'b1, {tag, " reset rise"}, wdt_rst, 1);
    for (int i = 0; i < 15; i++) begin
      @(posedge clk); @(negedge clk);
      if (!wdt_rst) lows++;
    end
    check(lows == 0, "R8 pulse hold", lows, 0);
    @(posedge clk); @(negedge clk);
    check(wdt_rst === 1'b0, "R8 pulse end", wdt_rst, 0);
  endtask

  task automatic hold_idle(input int n);
    @(negedge clk); idle = 1'b1; repeat (n) @(posedge clk); @(negedge clk); idle = 1'b0;
  endtask
  task automatic hold_pd(input int n);
    @(negedge clk); pwrdn = 1'b1; repeat (n) @(posedge clk); @(negedge clk); pwrdn = 1'b0;
  endtask
  task automatic hold_noen(input int n);
    @(negedge clk); clk_en = 1'b0; repeat (n) @(posedge clk); @(negedge clk); clk_en = 1'b1;
  endtask

  initial begin
    int highs;
    void'($urandom(32'h5eed_0a17));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(wdt_rst === 1'b0, "R1 reset request low", wdt_rst, 0);
    check(wdt_status === 1'b0, "R1 status low", wdt_status, 0);

    // R2: stopped, service ignored
    wr(2'd0, 8'hFF);
    service();
    highs = 0;
    for (int i = 0; i < 700; i++) begin
      @(posedge clk); @(negedge clk);
      if (wdt_rst) highs++;
    end
    check(highs == 0, "R2 stopped no reset", highs, 0);

    // R2/R3: start, 512 cycle timeout; R8 auto restart; R9 status
    pulse_start();
    chk_timeout(exp_period(8'hFF, 0), "R3 start sel0 FF");
    check(wdt_status === 1'b1, "R9 status set", wdt_status, 1);
    chk_timeout(496, "R8 auto restart");
    wr(2'd1, 8'h02);
    @(negedge clk);
    check(wdt_status === 1'b0, "R9 status clear", wdt_status, 1'b0);

    // R4: second service restarts timeout in full
    service();
    repeat (300) @(posedge clk);
    service();
    chk_timeout(512, "R4 reservice");

    // R5: interleaved access cancels, lone confirm ignored
    service();
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFF);
    wr(2'd3, 8'h00);
    wr(2'd3, 8'h00);
    chk_timeout(508, "R5 cancelled arm");

    // R6: new reload applies at next load only
    service();
    wr(2'd0, 8'hFE);
    chk_timeout(511, "R6 running count unchanged");
    chk_timeout(exp_period(8'hFE, 0) - 16, "R6 applied on restart");
    service();
    chk_timeout(1024, "R6 applied on service");
    wr(2'd0, 8'hFF);

    // R7: freeze inputs
    service();
    repeat (100) @(posedge clk);
    hold_idle(50);
    chk_timeout(412, "R7 idle freeze");
    service();
    repeat (10) @(posedge clk);
    hold_pd(30);
    repeat (10) @(posedge clk);
    hold_noen(20);
    chk_timeout(492, "R7 powerdown and enable freeze");

    // R3: divide by 128
    wr(2'd1, 8'h01);
    service();
    chk_timeout(exp_period(8'hFF, 1), "R3 sel1 FF");
    wr(2'd1, 8'h00);
    service();

    // R10: confirm on the overflow edge
    wr(2'd1, 8'h02);
    service();
    repeat (510) @(posedge clk);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);
    @(negedge clk);
    check(wdt_rst === 1'b0, "R10 no reset on tie", wdt_rst, 0);
    check(wdt_status === 1'b0, "R10 no status on tie", wdt_status, 0);
    chk_timeout(512, "R10 full timeout after tie");

    // R2: start while running ignored
    service();
    repeat (100) @(posedge clk);
    pulse_start();
    chk_timeout(411, "R2 start ignored");

    // random reloads, spurious cancelled services, idle gaps
    for (int it = 0; it < 6; it++) begin
      logic [7:0] r;
      int g, off, el;
      bit sp;
      r   = 8'hF0 | 8'($urandom % 16);
      g   = $urandom % 40;
      off = 1 + $urandom % 100;
      sp  = 1'($urandom % 2);
      wr(2'd0, r);
      service();
      el = 0;
      if (sp) begin
        wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd3, 8'h00);
        el = 3;
      end
      repeat (off) @(posedge clk);
      el += off;
      if (g > 0) hold_idle(g);
      chk_timeout(exp_period(r, 0) - el, "R3 R4 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule